// File: doc/BRIEF.md
# PCI Express Transmit Credit Gate

This block keeps the transmit-side flow-control books for one PCI Express link. It holds four credit pools: posted header, posted data, non-posted header and non-posted data. The pools start from the values the link partner advertised. Each transaction waiting to go out is presented with its kind and its payload length in doublewords. The gate grants it only when every pool it draws on holds enough credit. The partner's credit returns are added back as they arrive.

A grant is combinational and lasts for the cycle in which the request is presented. On the following clock edge the block subtracts the header credit and the data credits in one step, and in the same step adds whatever credits were returned. A request that does not fit is not dropped. It stays pending with the grant low until returns make room. Data credits are counted in 16-byte units, so a payload of N doublewords costs ceil(N/4) data credits.

Top module: `fc_credit_gate`

## Requirements
- R1: After reset all four credit counters read zero, and no request is granted until credits are loaded.
- R2: While `init_load` is high, the four counters take `init_ph`, `init_pd`, `init_nph` and `init_npd` at the next edge, returns are ignored, and `req_grant` is held low.
- R3: Request kinds are encoded on `req_type`. Codes 0 (memory read), 1 (IO read) and 2 (configuration read) need one non-posted header credit. Codes 3 (configuration write) and 4 (IO write) need one non-posted header credit plus non-posted data credits. Codes 5 (memory write) and 6 (message write) need one posted header credit plus posted data credits.
- R4: The data credits a request needs equal `req_len` (in doublewords) divided by four, rounded up. A length of zero needs no data credit.
- R5: `req_grant` is high only when `req_valid` is high and every pool the request needs holds at least the needed amount. A request that does not fit sees the grant low, leaves the counters unchanged, and is granted once returns make room.
- R6: The grant appears in the same cycle as the request, and the needed credits are subtracted at the next clock edge.
- R7: Each cycle the `ret_*` amounts are added to their pools. When a grant and a return fall in the same cycle, the counter becomes count minus need plus return. The grant decision in that cycle uses the count held before the return.
- R8: A return that would push a counter past its maximum (255 for headers, 4095 for data at default widths) leaves it at that maximum.
- R9: Code 7 is reserved. It is never granted and changes no counter.
- R10: A posted grant leaves both non-posted counters unchanged, and a non-posted grant leaves both posted counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_load | input | 1 | Load the advertised initial credits |
| init_ph | input | HDR_W | Initial posted header credits |
| init_pd | input | DATA_W | Initial posted data credits |
| init_nph | input | HDR_W | Initial non-posted header credits |
| init_npd | input | DATA_W | Initial non-posted data credits |
| req_valid | input | 1 | A transaction is pending |
| req_type | input | 3 | Transaction kind code |
| req_len | input | LEN_W | Payload length in doublewords |
| req_grant | output | 1 | Transaction may be sent this cycle |
| ret_ph | input | HDR_W | Posted header credits returned this cycle |
| ret_pd | input | DATA_W | Posted data credits returned this cycle |
| ret_nph | input | HDR_W | Non-posted header credits returned this cycle |
| ret_npd | input | DATA_W | Non-posted data credits returned this cycle |
| cnt_ph | output | HDR_W | Posted header credits available |
| cnt_pd | output | DATA_W | Posted data credits available |
| cnt_nph | output | HDR_W | Non-posted header credits available |
| cnt_npd | output | DATA_W | Non-posted data credits available |

## Verification
A table of requests walks every kind code through a pool that starts from the advertised values (8, 64, 4, 2). Lengths 0, 1, 4, 5, 16, 232 and 233 separate exact multiples of four from the rounded-up cases. The table then drains each pool until a request just fits and the next one just misses, which tells a strict comparison from a non-strict one. Directed cases pair a grant with a return in the same cycle, hold a blocked request until a return frees it, press a load against a pending request, and push a return into the saturation limit.

// File: rtl/fc_credit_gate.sv
module fc_credit_gate #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_load,
  input  logic [HDR_W-1:0]  init_ph,
  input  logic [DATA_W-1:0] init_pd,
  input  logic [HDR_W-1:0]  init_nph,
  input  logic [DATA_W-1:0] init_npd,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_grant,
  input  logic [HDR_W-1:0]  ret_ph,
  input  logic [DATA_W-1:0] ret_pd,
  input  logic [HDR_W-1:0]  ret_nph,
  input  logic [DATA_W-1:0] ret_npd,
  output logic [HDR_W-1:0]  cnt_ph,
  output logic [DATA_W-1:0] cnt_pd,
  output logic [HDR_W-1:0]  cnt_nph,
  output logic [DATA_W-1:0] cnt_npd
);
  localparam logic [31:0] HDR_MAX  = 32'((64'd1 << HDR_W) - 1);
  localparam logic [31:0] DATA_MAX = 32'((64'd1 << DATA_W) - 1);

  logic [LEN_W:0] len_up, need_d;
  logic is_post, is_np_rd, is_np_wr, fits;
  logic [31:0] take_ph, take_pd, take_nph, take_npd;
  logic [31:0] nx_ph, nx_pd, nx_nph, nx_npd;

  function automatic logic [31:0] settle(input logic [31:0] c, input logic [31:0] t,
                                         input logic [31:0] r, input logic [31:0] m);
    logic [32:0] s;
    s = {1'b0, c} - {1'b0, t} + {1'b0, r};
    return (s > {1'b0, m}) ? m : s[31:0];
  endfunction

  assign len_up   = {1'b0, req_len} + (LEN_W+1)'(3);
  assign need_d   = len_up >> 2;

  assign is_np_rd = (req_type <= 3'd2);
  assign is_np_wr = (req_type == 3'd3) || (req_type == 3'd4);
  assign is_post  = (req_type == 3'd5) || (req_type == 3'd6);

  always_comb begin
    if (is_post)
      fits = (cnt_ph != '0) && (32'(cnt_pd) >= 32'(need_d));
    else if (is_np_wr)
      fits = (cnt_nph != '0) && (32'(cnt_npd) >= 32'(need_d));
    else if (is_np_rd)
      fits = (cnt_nph != '0);
    else
      fits = 1'b0;
  end

  assign req_grant = req_valid && !init_load && fits;

  assign take_ph  = (req_grant && is_post) ? 32'd1 : 32'd0;
  assign take_pd  = (req_grant && is_post) ? 32'(need_d) : 32'd0;
  assign take_nph = (req_grant && (is_np_rd || is_np_wr)) ? 32'd1 : 32'd0;
  assign take_npd = (req_grant && is_np_wr) ? 32'(need_d) : 32'd0;

  assign nx_ph  = settle(32'(cnt_ph),  take_ph,  32'(ret_ph),  HDR_MAX);
  assign nx_pd  = settle(32'(cnt_pd),  take_pd,  32'(ret_pd),  DATA_MAX);
  assign nx_nph = settle(32'(cnt_nph), take_nph, 32'(ret_nph), HDR_MAX);
  assign nx_npd = settle(32'(cnt_npd), take_npd, 32'(ret_npd), DATA_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_ph  <= '0;
      cnt_pd  <= '0;
      cnt_nph <= '0;
      cnt_npd <= '0;
    end else if (init_load) begin
      cnt_ph  <= init_ph;
      cnt_pd  <= init_pd;
      cnt_nph <= init_nph;
      cnt_npd <= init_npd;
    end else begin
      cnt_ph  <= nx_ph[HDR_W-1:0];
      cnt_pd  <= nx_pd[DATA_W-1:0];
      cnt_nph <= nx_nph[HDR_W-1:0];
      cnt_npd <= nx_npd[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/fc_credit_gate_chk.sv
module fc_credit_gate_chk #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_load,
  input logic [HDR_W-1:0]  init_ph,
  input logic [DATA_W-1:0] init_pd,
  input logic [HDR_W-1:0]  init_nph,
  input logic [DATA_W-1:0] init_npd,
  input logic              req_valid,
  input logic [2:0]        req_type,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_grant,
  input logic [HDR_W-1:0]  ret_ph,
  input logic [DATA_W-1:0] ret_pd,
  input logic [HDR_W-1:0]  ret_nph,
  input logic [DATA_W-1:0] ret_npd,
  input logic [HDR_W-1:0]  cnt_ph,
  input logic [DATA_W-1:0] cnt_pd,
  input logic [HDR_W-1:0]  cnt_nph,
  input logic [DATA_W-1:0] cnt_npd
);
  logic [31:0] need;
  logic posted, no_ret;
  assign need   = (32'(req_len) + 32'd3) / 32'd4;
  assign posted = (req_type == 3'd5) || (req_type == 3'd6);
  assign no_ret = (ret_ph == '0) && (ret_pd == '0) && (ret_nph == '0) && (ret_npd == '0);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_type == 3'd7) |-> !req_grant);

  p_load_nogrant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |-> !req_grant);

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> (cnt_ph == $past(init_ph)) && (cnt_pd == $past(init_pd)) &&
                  (cnt_nph == $past(init_nph)) && (cnt_npd == $past(init_npd)));

  p_grant_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant && posted) |-> (cnt_ph != '0) && (32'(cnt_pd) >= need));

  p_grant_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> req_valid);

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_load && !req_grant && no_ret) |=>
      $stable(cnt_ph) && $stable(cnt_pd) && $stable(cnt_nph) && $stable(cnt_npd));

  p_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant && posted && no_ret) |=>
      (32'(cnt_ph) == 32'($past(cnt_ph)) - 32'd1) &&
      (32'(cnt_pd) == 32'($past(cnt_pd)) - $past(need)));

  p_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant && posted && ret_nph == '0 && ret_npd == '0) |=>
      $stable(cnt_nph) && $stable(cnt_npd));
endmodule

bind fc_credit_gate fc_credit_gate_chk #(.HDR_W(HDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/fc_credit_gate_tb.sv
module fc_credit_gate_tb;
  localparam int HDR_W = 8, DATA_W = 12, LEN_W = 11;

  logic clk = 1'b0, rst_n = 1'b0, init_load = 1'b0, req_valid = 1'b0;
  logic [HDR_W-1:0]  init_ph = '0, init_nph = '0, ret_ph = '0, ret_nph = '0;
  logic [DATA_W-1:0] init_pd = '0, init_npd = '0, ret_pd = '0, ret_npd = '0;
  logic [2:0]        req_type = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_grant;
  logic [HDR_W-1:0]  cnt_ph, cnt_nph;
  logic [DATA_W-1:0] cnt_pd, cnt_npd;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  fc_credit_gate #(.HDR_W(HDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (.*);

  // {type, len, grant, ph, pd, nph, npd after the edge}
  localparam logic [54:0] VEC [12] = '{
    {3'd5, 11'd16,  1'b1, 8'd7, 12'd60, 8'd4, 12'd2},
    {3'd5, 11'd5,   1'b1, 8'd6, 12'd58, 8'd4, 12'd2},
    {3'd6, 11'd0,   1'b1, 8'd5, 12'd58, 8'd4, 12'd2},
    {3'd0, 11'd0,   1'b1, 8'd5, 12'd58, 8'd3, 12'd2},
    {3'd3, 11'd1,   1'b1, 8'd5, 12'd58, 8'd2, 12'd1},
    {3'd4, 11'd4,   1'b1, 8'd5, 12'd58, 8'd1, 12'd0},
    {3'd4, 11'd1,   1'b0, 8'd5, 12'd58, 8'd1, 12'd0},
    {3'd1, 11'd0,   1'b1, 8'd5, 12'd58, 8'd0, 12'd0},
    {3'd2, 11'd0,   1'b0, 8'd5, 12'd58, 8'd0, 12'd0},
    {3'd5, 11'd233, 1'b0, 8'd5, 12'd58, 8'd0, 12'd0},
    {3'd5, 11'd232, 1'b1, 8'd4, 12'd0,  8'd0, 12'd0},
    {3'd7, 11'd0,   1'b0, 8'd4, 12'd0,  8'd0, 12'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int ph, input int pd, input int nph, input int npd);
    chk(req, "cnt_ph", int'(cnt_ph), ph);
    chk(req, "cnt_pd", int'(cnt_pd), pd);
    chk(req, "cnt_nph", int'(cnt_nph), nph);
    chk(req, "cnt_npd", int'(cnt_npd), npd);
  endtask

  task automatic load(input int ph, input int pd, input int nph, input int npd);
    @(negedge clk);
    init_load = 1'b1;
    init_ph = HDR_W'(ph); init_pd = DATA_W'(pd);
    init_nph = HDR_W'(nph); init_npd = DATA_W'(npd);
    @(negedge clk);
    init_load = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk_cnt("R1", 0, 0, 0, 0);
    req_valid = 1'b1; req_type = 3'd0; #1;
    chk("R1", "grant with empty pools", int'(req_grant), 0);
    req_valid = 1'b0;
    rst_n = 1'b1;

    // R2: load, and grant held low during load
    @(negedge clk);
    init_load = 1'b1; init_ph = 8'd8; init_pd = 12'd64; init_nph = 8'd4; init_npd = 12'd2;
    ret_ph = 8'd3; req_valid = 1'b1; req_type = 3'd5; req_len = 11'd4; #1;
    chk("R2", "grant during load", int'(req_grant), 0);
    @(negedge clk);
    init_load = 1'b0; ret_ph = '0; req_valid = 1'b0;
    chk_cnt("R2", 8, 64, 4, 2);

    // R3 R4 R5 R6 R9 R10: table walk
    for (int i = 0; i < 12; i++) begin
      req_type  = VEC[i][54:52];
      req_len   = VEC[i][51:41];
      req_valid = 1'b1;
      #1;
      chk("R3/R4/R5/R6", $sformatf("vec%0d grant", i), int'(req_grant), int'(VEC[i][40]));
      @(negedge clk);
      req_valid = 1'b0;
      chk_cnt($sformatf("R3/R4/R10/R9 vec%0d", i), int'(VEC[i][39:32]), int'(VEC[i][31:20]),
              int'(VEC[i][19:12]), int'(VEC[i][11:0]));
    end

    // R7: grant and return in the same cycle
    load(5, 10, 3, 3);
    req_valid = 1'b1; req_type = 3'd5; req_len = 11'd8; ret_pd = 12'd5; ret_nph = 8'd2; #1;
    chk("R7", "grant with return", int'(req_grant), 1);
    @(negedge clk);
    req_valid = 1'b0; ret_pd = '0; ret_nph = '0;
    chk_cnt("R7", 4, 13, 5, 3);

    // R5 R7: blocked request waits; return counts only from the next cycle
    load(0, 20, 0, 0);
    req_valid = 1'b1; req_type = 3'd6; req_len = 11'd3; ret_ph = 8'd1; #1;
    chk("R7", "grant before return lands", int'(req_grant), 0);
    @(negedge clk);
    ret_ph = '0; #1;
    chk("R5", "held request granted after return", int'(req_grant), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk_cnt("R5", 0, 19, 0, 0);

    // R8: saturation on return
    load(250, 4090, 254, 4095);
    ret_ph = 8'd10; ret_pd = 12'd20; ret_nph = 8'd1; ret_npd = 12'd1;
    @(negedge clk);
    ret_ph = '0; ret_pd = '0; ret_nph = '0; ret_npd = '0;
    chk_cnt("R8", 255, 4095, 255, 4095);

    // R9: reserved code with full pools
    req_valid = 1'b1; req_type = 3'd7; req_len = 11'd4; #1;
    chk("R9", "reserved grant", int'(req_grant), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk_cnt("R9", 255, 4095, 255, 4095);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule